// File: doc/BRIEF.md
# Program and Erase Completion Status Reporter

This block produces everything a host can observe while an internally timed byte program or whole-array erase is running. A qualified start pulse loads a cycle counter with the programmed or erase duration. While the counter runs, the active-high `ready` line is held low. A single-cycle `done` pulse marks a completion that was not interrupted.

During the operation, read data from the array is rewritten before it reaches the host. This gives the host two more ways to detect completion. The polling bit (bit 7) returns the complement of the loaded byte's bit 7; an erase counts as having loaded all ones. The toggle bit (bit 6) inverts after every completed read access. All other bits pass through unchanged.

Once the operation ends, reads carry true array data. A low level on the functional halt input aborts any operation without a completion pulse and disables the host data drivers. Start requests are accepted only when the supply is healthy, the bus is in a legal write state and no operation is already running.

Top module: `pes_status`

## Requirements
- R1: After reset `ready` is 1, `done` is 0, and `host_rdata` equals `arr_rdata`.
- R2: An accepted program start holds `ready` at 0 for exactly PROG_CYCLES clock cycles. `done` is then 1 for exactly one cycle, the first cycle with `ready` back at 1.
- R3: An accepted erase start holds `ready` at 0 for exactly ERASE_CYCLES clock cycles, followed by the same one-cycle `done` pulse.
- R4: While a program is running, bit 7 of `host_rdata` is the inverse of `load_poll_bit` as sampled on the start cycle, whatever the array supplies on bit 7.
- R5: While an operation is running, bit 6 of `host_rdata` is 0 in the first read after the start. It inverts once in the cycle after each falling edge of `rd_strobe`, and holds otherwise.
- R6: Bits 5 to 0 always pass `arr_rdata` through. Once `ready` is 1, all bits equal `arr_rdata`, and repeated reads no longer change bit 6.
- R7: A start pulse is ignored, leaving `ready` at 1, in any of these cases: `supply_low` is 1, `bus_oe_n` is 0, `bus_ce_n` is 1, or `bus_we_n` is 1. When `start_prog` and `start_erase` arrive together, program takes priority.
- R8: A start pulse that arrives while `ready` is 0 is ignored. The running duration and the polled bit value stay unchanged.
- R9: When `halt_n` is 0 on a clock edge, `ready` is 1 after that edge. No `done` pulse is issued for the aborted operation.
- R10: `rd_drive` is 1 only while `rd_strobe` is 1 and `halt_n` is 1.
- R11: While an erase is running, bit 7 of `host_rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_n | input | 1 | Functional abort, active low; disables data drive |
| start_prog | input | 1 | Byte program start request pulse |
| start_erase | input | 1 | Whole-array erase start request pulse |
| load_poll_bit | input | 1 | Bit 7 of the byte being programmed |
| supply_low | input | 1 | Supply below safe write level |
| bus_oe_n | input | 1 | Host output enable level, active low |
| bus_ce_n | input | 1 | Host chip enable level, active low |
| bus_we_n | input | 1 | Host write enable level, active low |
| rd_strobe | input | 1 | High during a host read access |
| arr_rdata | input | DATA_W | Data read from the array |
| host_rdata | output | DATA_W | Data returned to the host |
| rd_drive | output | 1 | Host data driver enable |
| ready | output | 1 | Low while an operation runs |
| done | output | 1 | One-cycle pulse on uninterrupted completion |

## Verification
Some properties are checked on every cycle. The polling bit stays constant during an operation. The toggle bit inverts exactly after a read access ends and holds otherwise. `done` only follows a busy cycle, and a low `halt_n` clears `ready`, suppresses `done` and disables the drivers. `ready` only falls after a start request. Other behaviour needs the bench's scenarios to show it:
- the exact operation lengths;
- the polled bit value taken from the loaded byte;
- each start guard on its own;
- a second start ignored mid-operation;
- true data returned once the operation ends.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef enum logic [0:0] {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/pes_guard.sv
module pes_guard
  import pes_pkg::*;
(
  input  logic     start_prog,
  input  logic     start_erase,
  input  logic     load_poll_bit,
  input  logic     supply_low,
  input  logic     bus_oe_n,
  input  logic     bus_ce_n,
  input  logic     bus_we_n,
  input  logic     busy,
  input  logic     halt_n,
  output logic     go,
  output op_kind_e kind,
  output logic     poll_bit
);
  logic bus_ok;

  always_comb begin
    bus_ok = !supply_low && bus_oe_n && !bus_ce_n && !bus_we_n;
    go     = (start_prog || start_erase) && bus_ok && !busy && halt_n;
    // program wins when both requests coincide
    if (start_prog) begin
      kind     = OP_PROG;
      poll_bit = load_poll_bit;
    end else begin
      kind     = OP_ERASE;
      poll_bit = 1'b1;
    end
  end
endmodule

// File: rtl/pes_timer.sv
module pes_timer
  import pes_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 1000,
  parameter int unsigned ERASE_CYCLES = 1000000000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     halt_n,
  input  logic     go,
  input  op_kind_e kind,
  output logic     busy,
  output logic     done
);
  localparam int unsigned MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!halt_n) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (go) begin
      busy_d = 1'b1;
      cnt_d  = (kind == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/pes_toggle.sv
module pes_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic busy,
  input  logic rd_strobe,
  output logic tog
);
  logic strb_q;
  logic tog_q, tog_d;
  logic rd_end;

  always_comb begin
    rd_end = strb_q && !rd_strobe;
    tog_d  = tog_q;
    if (go) begin
      tog_d = 1'b0;
    end else if (busy && rd_end) begin
      tog_d = !tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      strb_q <= rd_strobe;
      tog_q  <= tog_d;
    end
  end

  assign tog = tog_q;
endmodule

// File: rtl/pes_status.sv
module pes_status
  import pes_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned POLL_BIT     = 7,
  parameter int unsigned TOG_BIT      = 6,
  parameter int unsigned PROG_CYCLES  = 1000,
  parameter int unsigned ERASE_CYCLES = 1000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              load_poll_bit,
  input  logic              supply_low,
  input  logic              bus_oe_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              rd_drive,
  output logic              ready,
  output logic              done
);
  logic     go;
  op_kind_e kind;
  logic     poll_bit;
  logic     busy;
  logic     tog;
  logic     poll_q, poll_d;

  pes_guard u_guard (
    .start_prog   (start_prog),
    .start_erase  (start_erase),
    .load_poll_bit(load_poll_bit),
    .supply_low   (supply_low),
    .bus_oe_n     (bus_oe_n),
    .bus_ce_n     (bus_ce_n),
    .bus_we_n     (bus_we_n),
    .busy         (busy),
    .halt_n       (halt_n),
    .go           (go),
    .kind         (kind),
    .poll_bit     (poll_bit)
  );

  pes_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .halt_n(halt_n),
    .go    (go),
    .kind  (kind),
    .busy  (busy),
    .done  (done)
  );

  pes_toggle u_toggle (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .busy     (busy),
    .rd_strobe(rd_strobe),
    .tog      (tog)
  );

  always_comb begin
    poll_d = go ? poll_bit : poll_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
    end else begin
      poll_q <= poll_d;
    end
  end

  always_comb begin
    host_rdata = arr_rdata;
    if (busy) begin
      host_rdata[POLL_BIT] = !poll_q;
      host_rdata[TOG_BIT]  = tog;
    end
    rd_drive = rd_strobe && halt_n;
    ready    = !busy;
  end
endmodule

// File: rtl/pes_status_chk.sv
module pes_status_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TOG_BIT  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_n,
  input logic              start_prog,
  input logic              start_erase,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] host_rdata,
  input logic              rd_drive,
  input logic              ready,
  input logic              done
);
  logic s1_q, s2_q;
  logic fell_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= rd_strobe;
      s2_q <= s1_q;
    end
  end

  assign fell_prev = s2_q && !s1_q;

  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && $past(!ready))); // R2

  AST_HALT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |=> !done); // R9

  AST_HALT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |=> ready); // R9

  AST_HALT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |-> !rd_drive); // R10

  AST_POLL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> (host_rdata[POLL_BIT] == $past(host_rdata[POLL_BIT]))); // R4

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready) && fell_prev) |-> (host_rdata[TOG_BIT] != $past(host_rdata[TOG_BIT]))); // R5

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready) && !fell_prev) |-> (host_rdata[TOG_BIT] == $past(host_rdata[TOG_BIT]))); // R5

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(start_prog || start_erase) && $past(halt_n))); // R7
endmodule

bind pes_status pes_status_chk #(
  .DATA_W  (DATA_W),
  .POLL_BIT(POLL_BIT),
  .TOG_BIT (TOG_BIT)
) u_chk (.*);

// File: tb/pes_status_bench.sv
module pes_status_bench;
  localparam int unsigned PROG_N  = 40;
  localparam int unsigned ERASE_N = 120;

  logic       clk = 1'b0;
  logic       rst_n, halt_n, start_prog, start_erase, load_poll_bit;
  logic       supply_low, bus_oe_n, bus_ce_n, bus_we_n, rd_strobe;
  logic [7:0] arr_rdata, host_rdata;
  logic       rd_drive, ready, done;

  int   n_chk  = 0;
  int   n_fail = 0;
  logic sample_req = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  pes_status #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) u_pes_status (
    .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .start_prog(start_prog),
    .start_erase(start_erase), .load_poll_bit(load_poll_bit),
    .supply_low(supply_low), .bus_oe_n(bus_oe_n), .bus_ce_n(bus_ce_n),
    .bus_we_n(bus_we_n), .rd_strobe(rd_strobe), .arr_rdata(arr_rdata),
    .host_rdata(host_rdata), .rd_drive(rd_drive), .ready(ready), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design presents it
  always @(negedge clk) begin
    if (sample_req) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(host_rdata == e, t, "read data", host_rdata, e);
      check(rd_drive == 1'b1, "R10", "drive during read", rd_drive, 1);
    end
  end

  task automatic start_op(input bit erase, input bit pbit);
    @(posedge clk); #2;
    if (erase) start_erase = 1'b1; else start_prog = 1'b1;
    load_poll_bit = pbit;
    @(posedge clk); #2;
    start_prog  = 1'b0;
    start_erase = 1'b0;
  endtask

  // driver: one read access, expected data pushed to the scoreboard
  task automatic do_read(input logic [7:0] arr, input logic [7:0] exp, input string req);
    @(posedge clk); #2;
    rd_strobe = 1'b1;
    arr_rdata = arr;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    sample_req = 1'b1;
    @(posedge clk); #2;
    sample_req = 1'b0;
    rd_strobe  = 1'b0;
  endtask

  task automatic measure(input string req, input int exp_len, input bit poke);
    int n = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      n++;
      if (poke && n == 3) start_prog = 1'b1;
      if (poke && n == 4) start_prog = 1'b0;
    end
    check(n == exp_len, req, "busy length", n, exp_len);
    check(done == 1'b1, req, "done pulse", done, 1);
    @(negedge clk);
    check(done == 1'b0, req, "done single cycle", done, 0);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; halt_n = 1'b1; start_prog = 1'b0; start_erase = 1'b0;
    load_poll_bit = 1'b0; supply_low = 1'b0; bus_oe_n = 1'b1; bus_ce_n = 1'b0;
    bus_we_n = 1'b0; rd_strobe = 1'b0; arr_rdata = 8'hC3;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1", "ready after reset", ready, 1);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(host_rdata == 8'hC3, "R1", "passthrough", host_rdata, 8'hC3);

    // R2 program length
    start_op(1'b0, 1'b0);
    measure("R2", PROG_N, 1'b0);

    // R4 R5 polling and toggle during program, loaded bit 7 = 0
    start_op(1'b0, 1'b0);
    do_read(8'h00, 8'h80, "R4_R5 read1");
    do_read(8'h00, 8'hC0, "R5 read2");
    do_read(8'h15, 8'h95, "R5_R6 read3");
    do_read(8'h00, 8'hC0, "R5 read4");
    wait_ready();
    do_read(8'h5A, 8'h5A, "R6 true data");
    do_read(8'h5A, 8'h5A, "R6 bit6 frozen");

    // R4 loaded bit 7 = 1 polls as 0
    start_op(1'b0, 1'b1);
    do_read(8'hFF, 8'h3F, "R4 poll inverse");
    wait_ready();

    // R3 erase length, R8 start during busy does not disturb it
    start_op(1'b1, 1'b0);
    measure("R3_R8", ERASE_N, 1'b1);

    // R8 polled value kept when a second start arrives
    start_op(1'b0, 1'b1);
    start_op(1'b0, 1'b0);
    do_read(8'h80, 8'h00, "R8 poll kept");
    wait_ready();

    // R11 erase polls 0, then R9 and R10 halt
    start_op(1'b1, 1'b0);
    do_read(8'hFF, 8'h3F, "R11 erase poll");
    @(posedge clk); #2;
    halt_n = 1'b0;
    rd_strobe = 1'b1;
    @(negedge clk);
    check(rd_drive == 1'b0, "R10", "drive while halted", rd_drive, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(ready == 1'b1, "R9", "ready after halt", ready, 1);
      check(done == 1'b0, "R9", "no done on abort", done, 0);
    end
    @(posedge clk); #2;
    halt_n = 1'b1;
    rd_strobe = 1'b0;
    repeat (ERASE_N + 5) begin
      @(negedge clk);
      if (done) check(1'b0, "R9", "late done", 1, 0);
    end
    check(ready == 1'b1, "R9", "still idle", ready, 1);

    // R7 guards
    for (int g = 0; g < 4; g++) begin
      supply_low = (g == 0); bus_oe_n = (g != 1);
      bus_ce_n = (g == 2); bus_we_n = (g == 3);
      start_op(1'b0, 1'b0);
      @(negedge clk);
      check(ready == 1'b1, "R7", $sformatf("guard %0d blocks start", g), ready, 1);
    end
    supply_low = 1'b0; bus_oe_n = 1'b1; bus_ce_n = 1'b0; bus_we_n = 1'b0;

    // R7 priority: both requests, program length wins
    @(posedge clk); #2;
    start_prog = 1'b1; start_erase = 1'b1;
    @(posedge clk); #2;
    start_prog = 1'b0; start_erase = 1'b0;
    measure("R7 priority", PROG_N, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule